// File: doc/BRIEF.md
# Nested Prioritised Interrupt Controller

This block gathers up to 32 synchronous peripheral interrupt lines and decides which one is offered to a processor core, and when. Each line has an enable bit, a pending bit, an active bit and a 4-bit implemented priority that sits in the upper nibble of an 8-bit field. A programmable group field splits that priority into a preemption level, which decides whether a line may interrupt a running handler, and a subpriority, which only orders lines that are waiting together.

Software reaches the state through a word-wide register bus. Enable and pending bits use separate write-one-to-set and write-one-to-clear addresses. A rising edge on a line input marks the line pending even while it is disabled. On the core side the block drives a request flag, the winning line number and that line's handler vector. The core answers with an entry pulse when it takes the handler and an exit pulse when it returns. Entered lines are kept on an internal stack, so handlers nest strictly by preemption level and unwind in reverse order.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and irq_req is low.
- R2: A write to 0x00 sets the enable bits where the data has ones, and a write to 0x04 clears them. Reads of either address return the enable vector, with line n in bit n.
- R3: Writes to 0x08 and 0x0C set and clear pending bits, and both addresses read the pending vector. A rising edge on irq_in[n] sets pending bit n even when line n is disabled. In a cycle where a pending bit is both set and cleared, the set wins.
- R4: Priority words start at 0x20 + 4k and hold lines 4k to 4k+3, with line 4k+j in bits [8j+7:8j]. Only bits [8j+7:8j+4] are stored, and the low nibble of each byte reads zero.
- R5: Bits [2:0] at 0x40 hold the group value g and read back as written. The preemption level of a line is its 4-bit priority shifted right by min(g,4).
- R6: irq_req is high exactly when some enabled, pending line has a preemption level strictly lower than that of the most recently entered active line, or when such a line exists and nothing is active. Equal levels never preempt.
- R7: Among the lines that qualify, the one with the lowest 4-bit priority wins, and ties go to the lowest line number. irq_vector equals 0x40 + 4 * irq_line.
- R8: core_enter while irq_req is high clears the winner's pending bit and sets its active bit. 0x10 reads the active vector and ignores writes.
- R9: core_exit clears the active bit of the most recently entered line still active. It is ignored when nothing is active, and it is ignored in a cycle that also carries an accepted core_enter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Peripheral interrupt lines, sampled for rising edges |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_req | output | 1 | A line is ready to be taken by the core |
| irq_line | output | 5 | Winning line number |
| irq_vector | output | 32 | Handler vector of the winning line |
| core_enter | input | 1 | Core takes the presented line this cycle |
| core_exit | input | 1 | Core leaves its current handler this cycle |

## Verification
The assertions assume that the interrupt lines and the handshake pulses are synchronous to clk. They also assume that the core enters a handler only for a line the block is presenting and exits only in the order it entered. The stimulus drives every input at the falling edge, raises core_enter only while a request is expected, and keeps core_exit balanced against the entries it has made. The one exception is a single test of exit on an empty stack, a case the block is required to ignore.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int GROUP_W = 3;

    localparam logic [7:0] ADR_EN_SET   = 8'h00;
    localparam logic [7:0] ADR_EN_CLR   = 8'h04;
    localparam logic [7:0] ADR_PD_SET   = 8'h08;
    localparam logic [7:0] ADR_PD_CLR   = 8'h0C;
    localparam logic [7:0] ADR_ACTIVE   = 8'h10;
    localparam logic [7:0] ADR_PRIO_LO  = 8'h20;
    localparam logic [7:0] ADR_PRIO_HI  = 8'h3C;
    localparam logic [7:0] ADR_GROUP    = 8'h40;

    localparam logic [31:0] VEC_BASE = 32'h0000_0040;

    typedef enum logic [2:0] {
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_PD_SET,
        SEL_PD_CLR,
        SEL_ACTIVE,
        SEL_PRIO,
        SEL_GROUP,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [7:0] addr);
        reg_sel_e s;
        s = SEL_NONE;
        if (addr == ADR_EN_SET)      s = SEL_EN_SET;
        else if (addr == ADR_EN_CLR) s = SEL_EN_CLR;
        else if (addr == ADR_PD_SET) s = SEL_PD_SET;
        else if (addr == ADR_PD_CLR) s = SEL_PD_CLR;
        else if (addr == ADR_ACTIVE) s = SEL_ACTIVE;
        else if (addr == ADR_GROUP)  s = SEL_GROUP;
        else if (addr >= ADR_PRIO_LO && addr <= ADR_PRIO_HI && addr[1:0] == 2'b00)
            s = SEL_PRIO;
        return s;
    endfunction

    function automatic logic [31:0] vector_of(input logic [7:0] line);
        return VEC_BASE + {22'b0, line, 2'b00};
    endfunction

endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_i,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [N-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lines_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_rise
        assign rise_o[g] = lines_i[g] & ~st_q.prev[g];
    end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N  = 32,
    parameter int PB = 4,
    parameter int LW = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid_i,
    input  logic                   bus_write_i,
    input  logic [7:0]             bus_addr_i,
    input  logic [31:0]            bus_wdata_i,
    output logic [31:0]            bus_rdata_o,
    input  logic [N-1:0]           rise_i,
    input  logic                   enter_i,
    input  logic [LW-1:0]          enter_line_i,
    input  logic                   exit_i,
    input  logic [LW-1:0]          exit_line_i,
    output logic [N-1:0]           en_o,
    output logic [N-1:0]           pend_o,
    output logic [N-1:0]           act_o,
    output logic [N-1:0][PB-1:0]   prio_o,
    output logic [GROUP_W-1:0]     group_o
);
    typedef struct packed {
        logic [N-1:0]         en;
        logic [N-1:0]         pend;
        logic [N-1:0]         act;
        logic [N-1:0][PB-1:0] prio;
        logic [GROUP_W-1:0]   group;
    } reg_st_t;

    reg_st_t st_d, st_q;

    reg_sel_e     sel;
    logic         wr;
    int           widx;
    logic [N-1:0] wmask;
    logic [N-1:0] enter_oh;
    logic [N-1:0] exit_oh;
    logic [N-1:0] pd_set;
    logic [N-1:0] pd_clr;

    always_comb begin
        sel      = decode_addr(bus_addr_i);
        wr       = bus_valid_i & bus_write_i;
        widx     = int'(bus_addr_i[7:2]) - int'(ADR_PRIO_LO[7:2]);
        wmask    = bus_wdata_i[N-1:0];
        enter_oh = enter_i ? (N'(1) << enter_line_i) : '0;
        exit_oh  = exit_i  ? (N'(1) << exit_line_i)  : '0;
    end

    always_comb begin
        st_d = st_q;

        if (wr && sel == SEL_EN_SET) st_d.en = st_q.en | wmask;
        if (wr && sel == SEL_EN_CLR) st_d.en = st_q.en & ~wmask;

        pd_set = rise_i | ((wr && sel == SEL_PD_SET) ? wmask : '0);
        pd_clr = enter_oh | ((wr && sel == SEL_PD_CLR) ? wmask : '0);
        st_d.pend = (st_q.pend & ~pd_clr) | pd_set;

        st_d.act = (st_q.act & ~exit_oh) | enter_oh;

        if (wr && sel == SEL_PRIO) begin
            for (int i = 0; i < N; i++) begin
                if (i / 4 == widx) st_d.prio[i] = bus_wdata_i[8*(i%4)+7 -: PB];
            end
        end

        if (wr && sel == SEL_GROUP) st_d.group = bus_wdata_i[GROUP_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (sel)
            SEL_EN_SET, SEL_EN_CLR: bus_rdata_o[N-1:0] = st_q.en;
            SEL_PD_SET, SEL_PD_CLR: bus_rdata_o[N-1:0] = st_q.pend;
            SEL_ACTIVE:             bus_rdata_o[N-1:0] = st_q.act;
            SEL_PRIO: begin
                for (int i = 0; i < N; i++) begin
                    if (i / 4 == widx) bus_rdata_o[8*(i%4)+7 -: PB] = st_q.prio[i];
                end
            end
            SEL_GROUP:              bus_rdata_o[GROUP_W-1:0] = st_q.group;
            default:                bus_rdata_o = '0;
        endcase
    end

    assign en_o    = st_q.en;
    assign pend_o  = st_q.pend;
    assign act_o   = st_q.act;
    assign prio_o  = st_q.prio;
    assign group_o = st_q.group;

    // R3
    pend_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_i) |=> ((st_q.pend & $past(rise_i)) == $past(rise_i)));

    // R8
    act_on_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter_i |=> st_q.act[$past(enter_line_i)]);

    // R8
    act_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_ACTIVE && !enter_i && !exit_i) |=> $stable(st_q.act));

endmodule

// File: rtl/irqc_select.sv
module irqc_select
    import irqc_pkg::*;
#(
    parameter int N  = 32,
    parameter int PB = 4,
    parameter int LW = 5
) (
    input  logic [N-1:0]         en_i,
    input  logic [N-1:0]         pend_i,
    input  logic [N-1:0][PB-1:0] prio_i,
    input  logic [GROUP_W-1:0]   group_i,
    input  logic                 ctx_valid_i,
    input  logic [PB-1:0]        ctx_prio_i,
    output logic                 req_o,
    output logic [LW-1:0]        line_o
);
    int            sb;
    logic [PB-1:0] ctx_pre;
    logic [N-1:0]  elig;

    always_comb begin
        sb      = (int'(group_i) > PB) ? PB : int'(group_i);
        ctx_pre = ctx_prio_i >> sb;
    end

    for (genvar g = 0; g < N; g++) begin : g_elig
        assign elig[g] = en_i[g] & pend_i[g] &
                         (!ctx_valid_i || ((prio_i[g] >> sb) < ctx_pre));
    end

    logic          found;
    logic [PB-1:0] best;
    logic [LW-1:0] best_line;

    always_comb begin
        found     = 1'b0;
        best      = '0;
        best_line = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!found || prio_i[i] < best)) begin
                found     = 1'b1;
                best      = prio_i[i];
                best_line = LW'(i);
            end
        end
    end

    assign req_o  = found;
    assign line_o = best_line;

endmodule

// File: rtl/irqc_nest.sv
module irqc_nest #(
    parameter int LW    = 5,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [LW-1:0] push_line_i,
    input  logic          pop_i,
    output logic          top_valid_o,
    output logic [LW-1:0] top_line_o
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][LW-1:0] stack;
        logic [CW-1:0]            cnt;
    } nest_st_t;

    nest_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (int'(st_q.cnt) == i) st_d.stack[i] = push_line_i;
            end
            if (int'(st_q.cnt) < DEPTH) st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop_i && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        top_line_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(st_q.cnt) - 1 == i) top_line_o = st_q.stack[i];
        end
    end

    assign top_valid_o = (st_q.cnt != '0);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (int'(st_q.cnt) < DEPTH));

    // R9
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> top_valid_o);

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_BITS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_LINES-1:0]         irq_in,
    input  logic                         bus_valid,
    input  logic                         bus_write,
    input  logic [7:0]                   bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    output logic                         irq_req,
    output logic [$clog2(NUM_LINES)-1:0] irq_line,
    output logic [31:0]                  irq_vector,
    input  logic                         core_enter,
    input  logic                         core_exit
);
    localparam int LINE_W     = $clog2(NUM_LINES);
    localparam int NEST_DEPTH = 1 << PRIO_BITS;

    logic [NUM_LINES-1:0]                rise;
    logic [NUM_LINES-1:0]                en;
    logic [NUM_LINES-1:0]                pend;
    logic [NUM_LINES-1:0]                act;
    logic [NUM_LINES-1:0][PRIO_BITS-1:0] prio;
    logic [GROUP_W-1:0]                  group;
    logic                                top_valid;
    logic [LINE_W-1:0]                   top_line;
    logic                                enter_fire;
    logic                                exit_fire;

    assign enter_fire = core_enter & irq_req;
    assign exit_fire  = core_exit & top_valid & ~enter_fire;

    irqc_edge #(.N(NUM_LINES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (irq_in),
        .rise_o  (rise)
    );

    irqc_regs #(.N(NUM_LINES), .PB(PRIO_BITS), .LW(LINE_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_valid_i  (bus_valid),
        .bus_write_i  (bus_write),
        .bus_addr_i   (bus_addr),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .rise_i       (rise),
        .enter_i      (enter_fire),
        .enter_line_i (irq_line),
        .exit_i       (exit_fire),
        .exit_line_i  (top_line),
        .en_o         (en),
        .pend_o       (pend),
        .act_o        (act),
        .prio_o       (prio),
        .group_o      (group)
    );

    irqc_select #(.N(NUM_LINES), .PB(PRIO_BITS), .LW(LINE_W)) u_select (
        .en_i        (en),
        .pend_i      (pend),
        .prio_i      (prio),
        .group_i     (group),
        .ctx_valid_i (top_valid),
        .ctx_prio_i  (prio[top_line]),
        .req_o       (irq_req),
        .line_o      (irq_line)
    );

    irqc_nest #(.LW(LINE_W), .DEPTH(NEST_DEPTH)) u_nest (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (enter_fire),
        .push_line_i (irq_line),
        .pop_i       (exit_fire),
        .top_valid_o (top_valid),
        .top_line_o  (top_line)
    );

    assign irq_vector = vector_of(8'(irq_line));

    // R6
    req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (en[irq_line] && pend[irq_line]));

    // R9
    exit_clears_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_fire |=> !act[$past(top_line)]);

    // R8
    enter_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_fire && !rise[irq_line]) |=> !pend[$past(irq_line)]);

endmodule

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;
    logic [4:0]  irq_line;
    logic [31:0] irq_vector;
    logic        core_enter = 1'b0;
    logic        core_exit = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nest_irq_ctrl u_nest_irq_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_req    (irq_req),
        .irq_line   (irq_line),
        .irq_vector (irq_vector),
        .core_enter (core_enter),
        .core_exit  (core_exit)
    );

    typedef enum int { OBS_READ, OBS_REQ } obs_e;
    typedef struct {
        obs_e        kind;
        string       tag;
        logic [31:0] exp;
        int          line;
    } item_t;

    item_t sbq[$];
    int n_cmp = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // monitor: samples a quarter period after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                n_cmp++;
                if (it.kind == OBS_READ) begin
                    if (bus_rdata !== it.exp) begin
                        n_fail++;
                        $display("FAIL %s: rdata=%h expected=%h", it.tag, bus_rdata, it.exp);
                    end
                end else begin
                    if (irq_req !== it.exp[0]) begin
                        n_fail++;
                        $display("FAIL %s: irq_req=%b expected=%b", it.tag, irq_req, it.exp[0]);
                    end else if (it.exp[0] &&
                                 (irq_line !== 5'(it.line) ||
                                  irq_vector !== 32'h40 + 32'(it.line) * 4)) begin
                        n_fail++;
                        $display("FAIL %s: line=%0d vector=%h expected line=%0d vector=%h",
                                 it.tag, irq_line, irq_vector, it.line, 32'h40 + 32'(it.line) * 4);
                    end
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic wr_with_rise(input logic [7:0] a, input logic [31:0] d, input int ln);
        @(negedge clk);
        irq_in[ln] = 1'b1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        it.kind = OBS_READ; it.tag = tag; it.exp = e; it.line = 0;
        sbq.push_back(it);
    endtask

    task automatic expect_req(input bit r, input int ln, input string tag);
        item_t it;
        @(negedge clk);
        bus_valid = 1'b0;
        it.kind = OBS_REQ; it.tag = tag; it.exp = {31'b0, r}; it.line = ln;
        sbq.push_back(it);
    endtask

    task automatic handshake(input bit ent, input bit ext);
        @(negedge clk);
        core_enter = ent; core_exit = ext;
        @(negedge clk);
        core_enter = 1'b0; core_exit = 1'b0;
    endtask

    task automatic drive_line(input int ln, input bit v);
        @(negedge clk);
        irq_in[ln] = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_rd(8'h00, 32'h0, "R1 enable");
        expect_rd(8'h08, 32'h0, "R1 pending");
        expect_rd(8'h10, 32'h0, "R1 active");
        expect_rd(8'h20, 32'h0, "R1 priority");
        expect_rd(8'h40, 32'h0, "R1 group");
        expect_req(1'b0, 0, "R1 request");

        // R2 enable set/clear
        wr(8'h00, 32'hF0);
        expect_rd(8'h00, 32'hF0, "R2 set read");
        expect_rd(8'h04, 32'hF0, "R2 clear-addr read");
        wr(8'h04, 32'h30);
        expect_rd(8'h00, 32'hC0, "R2 after clear");

        // R4 priority storage
        wr(8'h20, 32'h12345678);
        expect_rd(8'h20, 32'h10305070, "R4 low nibbles zero");

        // R3 pending via writes
        wr(8'h08, 32'h0F);
        expect_rd(8'h0C, 32'h0F, "R3 set pending");
        expect_req(1'b0, 0, "R6 disabled lines");
        wr(8'h0C, 32'h05);
        expect_rd(8'h08, 32'h0A, "R3 clear pending");

        // R7 winner by priority
        wr(8'h00, 32'h0F);
        expect_req(1'b1, 3, "R7 lowest priority wins");

        // R8 entry
        handshake(1'b1, 1'b0);
        expect_rd(8'h10, 32'h08, "R8 active set");
        expect_rd(8'h08, 32'h02, "R8 pending cleared");
        expect_req(1'b0, 0, "R6 no preempt by lower urgency");
        wr(8'h10, 32'hFFFFFFFF);
        expect_rd(8'h10, 32'h08, "R8 active ignores writes");

        // R9 exit then nesting
        handshake(1'b0, 1'b1);
        expect_rd(8'h10, 32'h00, "R9 exit clears active");
        expect_req(1'b1, 1, "R9 next line offered");
        handshake(1'b1, 1'b0);
        drive_line(2, 1'b1);
        expect_req(1'b1, 2, "R6 preempt 3 over 5");
        handshake(1'b1, 1'b0);
        expect_rd(8'h10, 32'h06, "R8 nested active");
        drive_line(0, 1'b1);
        expect_req(1'b0, 0, "R6 level 7 blocked by 3");
        wr(8'h20, 32'h30305070);
        wr(8'h08, 32'h08);
        expect_req(1'b0, 0, "R6 equal level blocked");
        handshake(1'b0, 1'b1);
        expect_rd(8'h10, 32'h02, "R9 most recent popped");
        expect_req(1'b1, 3, "R9 context back to 5");
        handshake(1'b0, 1'b1);
        expect_rd(8'h10, 32'h00, "R9 stack empty");
        expect_req(1'b1, 3, "R7 idle winner");

        // R5 group split
        wr(8'h0C, 32'hFFFFFFFF);
        wr(8'h20, 32'h00205060);
        wr(8'h40, 32'h2);
        expect_rd(8'h40, 32'h2, "R5 group readback");
        wr(8'h08, 32'h01);
        expect_req(1'b1, 0, "R5 single pending");
        handshake(1'b1, 1'b0);
        wr(8'h08, 32'h02);
        expect_req(1'b0, 0, "R5 same preempt level with g=2");
        wr(8'h40, 32'h0);
        expect_req(1'b1, 1, "R5 preempts with g=0");
        handshake(1'b1, 1'b0);
        handshake(1'b0, 1'b1);
        handshake(1'b0, 1'b1);
        handshake(1'b0, 1'b1);
        expect_rd(8'h10, 32'h00, "R9 exit on empty ignored");
        expect_req(1'b0, 0, "R9 nothing pending");

        // R7 tie
        wr(8'h20, 32'h00505060);
        wr(8'h08, 32'h06);
        expect_req(1'b1, 1, "R7 tie lowest line");

        // R9 enter and exit together
        handshake(1'b1, 1'b1);
        expect_rd(8'h10, 32'h02, "R9 enter wins over exit");
        expect_rd(8'h08, 32'h04, "R9 pending after enter");
        expect_req(1'b0, 0, "R6 equal level blocked again");

        // R3 edge on disabled line, set beats clear
        wr_with_rise(8'h0C, 32'h20, 5);
        expect_rd(8'h08, 32'h24, "R3 edge beats clear on disabled line");
        expect_req(1'b0, 0, "R3 disabled line not offered");
        wr(8'h00, 32'h20);
        expect_req(1'b1, 5, "R3 offered once enabled");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule